// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 device from power-on to a state where it will accept normal commands. It walks through a fixed table of eight steps. Each step carries four flags (use a timer, hold the command, CKE level, RESET# level), a four-bit DRAM command, and a 24-bit field. That field is either a wait length in controller cycles or a mode-register payload holding the bank and address. The table is built at elaboration. Its nanosecond delays are turned into controller cycles by dividing by the clock period and rounding up. The timing assumes a controller clock that runs at one quarter of the DRAM clock.

The steps run in this order. First, RESET# is held low with CKE low. Next, RESET# is released while CKE stays low. Then CKE rises and the block waits out the reset-exit time. After that come four back-to-back mode-register writes: MR2, MR3, MR1, MR0. The last step is a long ZQ calibration command followed by a fixed wait. When the final wait ends, `init_done` rises and stays high. ODT stays low throughout. A synchronous active-low reset restarts the whole sequence from the first step.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs after that edge are: RESET# low, CKE low, command NOP, bank 0, address 0, `init_done` low. Command bits are {cs_n, ras_n, cas_n, we_n}, and NOP is 0111.
- R2: Once reset is released, the first step lasts ceil(T_RESET_NS*1000/CLK_PERIOD_PS) cycles with RESET# low, CKE low and NOP.
- R3: The second step lasts ceil(T_CKE_NS*1000/CLK_PERIOD_PS) cycles with RESET# high, CKE low and NOP. CKE is never high while RESET# is low.
- R4: The third step lasts ceil(T_XPR_NS*1000/CLK_PERIOD_PS) cycles with CKE high and NOP. The cycle just before CKE rises always shows NOP.
- R5: In the next four cycles, mode-register writes (command 0000) go out with no gap. In order, they carry bank 2 with MR2_VAL, bank 3 with MR3_VAL, bank 1 with MR1_VAL, and bank 0 with MR0_VAL on the address bus. RESET# and CKE are high.
- R6: A long ZQ calibration command (0110) follows for one cycle, with address bit 10 set and every other address and bank bit zero. NOP then fills the remaining ZQ_INIT_CYCLES-1 cycles, because this step does not hold its command.
- R7: `init_done` rises in the cycle after the ZQ wait ends and then stays high. While it is high, RESET# and CKE are high and the command is NOP.
- R8: ODT is low in every cycle.
- R9: Pulling `rst_n` low partway through the sequence brings the outputs back to the R1 state at the next edge. Releasing it replays the whole sequence from the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (one quarter of the DRAM clock rate) |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| ddr_reset_n | output | 1 | DRAM RESET# |
| ddr_cke | output | 1 | DRAM clock enable |
| ddr_odt | output | 1 | DRAM on-die termination, always low |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once the sequence has finished |

## Verification
The hardest case to reach from the ports is a reset that arrives in the middle of the sequence, after CKE has already gone high. In that case the step index, the cycle counter and the CKE level must all fall back at once, and the replay must repeat every step length exactly. The bench shortens all delays through parameters so that every phase takes only a few cycles. It lets one run finish, then starts a second run and asserts reset partway through the tXPR step. It checks the reset state and then compares a full replay cycle by cycle against a queue of expected pin values.

// File: rtl/ddr3i_pkg.sv
`timescale 1ns/1ps
package ddr3i_pkg;

  localparam int CMD_W     = 4;
  localparam int FIELD_W   = 24;
  localparam int BANK_W    = 3;
  localparam int BANK_LSB  = 16;
  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef logic [CMD_W-1:0] cmd_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam cmd_t CMD_MRS  = 4'b0000;
  localparam cmd_t CMD_ZQCL = 4'b0110;
  localparam cmd_t CMD_NOP  = 4'b0111;

  typedef struct packed {
    logic               use_timer;
    logic               hold_cmd;
    logic               cke;
    logic               rst_n;
    cmd_t               cmd;
    logic [FIELD_W-1:0] field;
  } step_t;

  // Round a nanosecond delay up to whole controller cycles, at least one.
  function automatic logic [FIELD_W-1:0] ns_to_cycles(input longint unsigned ns,
                                                      input longint unsigned period_ps);
    longint unsigned cyc;
    cyc = (ns * 64'd1000 + period_ps - 64'd1) / period_ps;
    if (cyc == 64'd0) cyc = 64'd1;
    if (cyc > ((64'd1 << FIELD_W) - 64'd1)) cyc = (64'd1 << FIELD_W) - 64'd1;
    return cyc[FIELD_W-1:0];
  endfunction

  // Mode-register payload: bank above the 16-bit address value.
  function automatic logic [FIELD_W-1:0] mrs_field(input logic [BANK_W-1:0] ba,
                                                   input logic [15:0] val);
    return {{(FIELD_W-BANK_LSB-BANK_W){1'b0}}, ba, val};
  endfunction

  function automatic step_t make_step(input logic [3:0] flags, input cmd_t cmd,
                                      input logic [FIELD_W-1:0] f);
    step_t s;
    s.use_timer = flags[3];
    s.hold_cmd  = flags[2];
    s.cke       = flags[1];
    s.rst_n     = flags[0];
    s.cmd       = cmd;
    s.field     = f;
    return s;
  endfunction

  // Cycles a step occupies: its count if timed, otherwise exactly one.
  function automatic logic [FIELD_W-1:0] step_load(input step_t s);
    if (!s.use_timer) return FIELD_W'(1);
    if (s.field == '0) return FIELD_W'(1);
    return s.field;
  endfunction

endpackage

// File: rtl/ddr3i_rom.sv
`timescale 1ns/1ps
module ddr3i_rom
  import ddr3i_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 5000,
  parameter int unsigned T_RESET_NS     = 200000,
  parameter int unsigned T_CKE_NS       = 500000,
  parameter int unsigned T_XPR_NS       = 120,
  parameter int unsigned ZQ_INIT_CYCLES = 128,
  parameter logic [15:0] MR0_VAL        = 16'h0520,
  parameter logic [15:0] MR1_VAL        = 16'h0044,
  parameter logic [15:0] MR2_VAL        = 16'h0008,
  parameter logic [15:0] MR3_VAL        = 16'h0000
) (
  input  logic [STEP_W-1:0] idx_a,
  input  logic [STEP_W-1:0] idx_b,
  output step_t             word_a,
  output step_t             word_b,
  output step_t             word_first
);

  function automatic step_t step_word(input int i);
    case (i)
      0:       return make_step(4'b1100, CMD_NOP, ns_to_cycles(T_RESET_NS, CLK_PERIOD_PS));
      1:       return make_step(4'b1101, CMD_NOP, ns_to_cycles(T_CKE_NS, CLK_PERIOD_PS));
      2:       return make_step(4'b1111, CMD_NOP, ns_to_cycles(T_XPR_NS, CLK_PERIOD_PS));
      3:       return make_step(4'b0011, CMD_MRS, mrs_field(3'd2, MR2_VAL));
      4:       return make_step(4'b0011, CMD_MRS, mrs_field(3'd3, MR3_VAL));
      5:       return make_step(4'b0011, CMD_MRS, mrs_field(3'd1, MR1_VAL));
      6:       return make_step(4'b0011, CMD_MRS, mrs_field(3'd0, MR0_VAL));
      7:       return make_step(4'b1011, CMD_ZQCL, FIELD_W'(ZQ_INIT_CYCLES));
      default: return make_step(4'b0011, CMD_NOP, '0);
    endcase
  endfunction

  step_t table_w [NUM_STEPS];

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_entry
    assign table_w[g] = step_word(g);
  end

  assign word_a     = table_w[idx_a];
  assign word_b     = table_w[idx_b];
  assign word_first = table_w[0];

endmodule

// File: rtl/ddr3i_step_timer.sv
`timescale 1ns/1ps
module ddr3i_step_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] init_val,
  input  logic         reload,
  input  logic [W-1:0] reload_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= init_val;
    else if (reload)       cnt_q <= reload_val;
    else if (cnt_q > W'(1)) cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == W'(1));

  AST_TIMER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);  // R2

endmodule

// File: rtl/ddr3i_pin_drv.sv
`timescale 1ns/1ps
module ddr3i_pin_drv
  import ddr3i_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  step_t              cur,
  input  logic               first,
  input  logic               done,
  output logic               reset_n,
  output logic               cke,
  output logic               odt,
  output cmd_t               cmd,
  output logic [BANK_W-1:0]  ba,
  output logic [ADDR_W-1:0]  addr
);

  localparam int ZQ_LONG_BIT = 10;

  always_comb begin
    reset_n = done ? 1'b1 : cur.rst_n;
    cke     = done ? 1'b1 : cur.cke;
    odt     = 1'b0;
    cmd     = CMD_NOP;
    ba      = '0;
    addr    = '0;
    if (!done && (first || cur.hold_cmd)) cmd = cur.cmd;
    if (cmd == CMD_MRS) begin
      ba   = cur.field[BANK_LSB +: BANK_W];
      addr = cur.field[ADDR_W-1:0];
    end else if (cmd == CMD_ZQCL) begin
      addr[ZQ_LONG_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/ddr3_init_seq.sv
`timescale 1ns/1ps
module ddr3_init_seq
  import ddr3i_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 5000,
  parameter int unsigned T_RESET_NS     = 200000,
  parameter int unsigned T_CKE_NS       = 500000,
  parameter int unsigned T_XPR_NS       = 120,
  parameter int unsigned ZQ_INIT_CYCLES = 128,
  parameter int          ADDR_W         = 14,
  parameter logic [15:0] MR0_VAL        = 16'h0520,
  parameter logic [15:0] MR1_VAL        = 16'h0044,
  parameter logic [15:0] MR2_VAL        = 16'h0008,
  parameter logic [15:0] MR3_VAL        = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [2:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic              first_q;
  logic              done_q;
  step_t             cur_step;
  step_t             nxt_step;
  step_t             first_step;
  logic              timer_expired;
  logic              step_end;
  logic              seq_last;
  logic              advance;
  cmd_t              cmd_bus;

  ddr3i_rom #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .T_RESET_NS    (T_RESET_NS),
    .T_CKE_NS      (T_CKE_NS),
    .T_XPR_NS      (T_XPR_NS),
    .ZQ_INIT_CYCLES(ZQ_INIT_CYCLES),
    .MR0_VAL       (MR0_VAL),
    .MR1_VAL       (MR1_VAL),
    .MR2_VAL       (MR2_VAL),
    .MR3_VAL       (MR3_VAL)
  ) u_rom (
    .idx_a     (step_q),
    .idx_b     (step_q + STEP_W'(1)),
    .word_a    (cur_step),
    .word_b    (nxt_step),
    .word_first(first_step)
  );

  assign step_end = timer_expired && !done_q;
  assign seq_last = (step_q == LAST_STEP);
  assign advance  = step_end && !seq_last;

  ddr3i_step_timer #(.W(FIELD_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_val  (step_load(first_step)),
    .reload    (advance),
    .reload_val(step_load(nxt_step)),
    .expired   (timer_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (step_end) begin
      if (seq_last) begin
        done_q  <= 1'b1;
        first_q <= 1'b0;
      end else begin
        step_q  <= step_q + STEP_W'(1);
        first_q <= 1'b1;
      end
    end else begin
      first_q <= 1'b0;
    end
  end

  ddr3i_pin_drv #(.ADDR_W(ADDR_W)) u_pins (
    .cur    (cur_step),
    .first  (first_q),
    .done   (done_q),
    .reset_n(ddr_reset_n),
    .cke    (ddr_cke),
    .odt    (ddr_odt),
    .cmd    (cmd_bus),
    .ba     (ddr_ba),
    .addr   (ddr_addr)
  );

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_bus;
  assign init_done = done_q;

  AST_CKE_AFTER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ddr_cke) |-> $past(cmd_bus) == CMD_NOP);  // R4
  AST_CKE_NEEDS_RESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |-> ddr_reset_n);  // R3
  AST_ODT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_odt);  // R8
  AST_MRS_WITH_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bus == CMD_MRS) |-> (ddr_cke && ddr_reset_n));  // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);  // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd_bus == CMD_NOP && ddr_cke && ddr_reset_n));  // R7

endmodule

// File: tb/ddr3_init_seq_tb.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb;

  localparam int unsigned P_PS   = 10000;
  localparam int unsigned TR_NS  = 95;
  localparam int unsigned TC_NS  = 200;
  localparam int unsigned TX_NS  = 41;
  localparam int unsigned ZQ_CYC = 8;
  localparam int          AW     = 14;
  localparam logic [15:0] MR0    = 16'h0520;
  localparam logic [15:0] MR1    = 16'h0044;
  localparam logic [15:0] MR2    = 16'h0008;
  localparam logic [15:0] MR3    = 16'h0004;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ddr_reset_n, ddr_cke, ddr_odt;
  logic          ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [2:0]    ddr_ba;
  logic [AW-1:0] ddr_addr;
  logic          init_done;

  always #5 clk = ~clk;

  ddr3_init_seq #(
    .CLK_PERIOD_PS(P_PS), .T_RESET_NS(TR_NS), .T_CKE_NS(TC_NS), .T_XPR_NS(TX_NS),
    .ZQ_INIT_CYCLES(ZQ_CYC), .ADDR_W(AW),
    .MR0_VAL(MR0), .MR1_VAL(MR1), .MR2_VAL(MR2), .MR3_VAL(MR3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_odt(ddr_odt),
    .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
  );

  typedef struct {
    bit          rst;
    bit          cke;
    bit [3:0]    cmd;
    bit [2:0]    ba;
    bit [AW-1:0] addr;
    bit          done;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;

  // Own rounding: whole part plus one if anything is left over.
  function automatic int cyc_of(input int unsigned ns);
    int unsigned total;
    total = ns * 1000;
    return int'(total / P_PS) + ((total % P_PS) != 0 ? 1 : 0);
  endfunction

  task automatic push(input bit r, input bit c, input bit [3:0] cmd, input bit [2:0] ba,
                      input bit [AW-1:0] a, input bit d, input string tag);
    exp_t e;
    e.rst = r; e.cke = c; e.cmd = cmd; e.ba = ba; e.addr = a; e.done = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: queue the expected pins, one item per cycle, up to 'limit' items.
  task automatic push_sequence(input int limit);
    int k = 0;
    bit [AW-1:0] zq_a = '0;
    zq_a[10] = 1'b1;
    for (int i = 0; i < cyc_of(TR_NS); i++) begin if (k < limit) push(0,0,4'b0111,0,0,0,"R2"); k++; end
    for (int i = 0; i < cyc_of(TC_NS); i++) begin if (k < limit) push(1,0,4'b0111,0,0,0,"R3"); k++; end
    for (int i = 0; i < cyc_of(TX_NS); i++) begin if (k < limit) push(1,1,4'b0111,0,0,0,"R4"); k++; end
    if (k < limit) push(1,1,4'b0000,3'd2,MR2[AW-1:0],0,"R5"); k++;
    if (k < limit) push(1,1,4'b0000,3'd3,MR3[AW-1:0],0,"R5"); k++;
    if (k < limit) push(1,1,4'b0000,3'd1,MR1[AW-1:0],0,"R5"); k++;
    if (k < limit) push(1,1,4'b0000,3'd0,MR0[AW-1:0],0,"R5"); k++;
    if (k < limit) push(1,1,4'b0110,0,zq_a,0,"R6"); k++;
    for (int i = 1; i < ZQ_CYC; i++) begin if (k < limit) push(1,1,4'b0111,0,0,0,"R6"); k++; end
    for (int i = 0; i < 5; i++) begin if (k < limit) push(1,1,4'b0111,0,0,1,"R7"); k++; end
  endtask

  // Monitor: called at a falling edge; pops and compares one item per cycle.
  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit [3:0] act_cmd;
        string tg;
        e = exp_q.pop_front();
        act_cmd = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
        checks++;
        if (ddr_reset_n !== e.rst || ddr_cke !== e.cke || ddr_odt !== 1'b0 ||
            act_cmd !== e.cmd || ddr_ba !== e.ba || ddr_addr !== e.addr ||
            init_done !== e.done) begin
          fails++;
          tg = (ddr_odt !== 1'b0) ? "R8" : e.tag;
          $display("FAIL %s t=%0t actual rst=%b cke=%b odt=%b cmd=%b ba=%0d addr=%h done=%b expected rst=%b cke=%b odt=0 cmd=%b ba=%0d addr=%h done=%b",
                   tg, $time, ddr_reset_n, ddr_cke, ddr_odt, act_cmd, ddr_ba, ddr_addr, init_done,
                   e.rst, e.cke, e.cmd, e.ba, e.addr, e.done);
        end
      end
      @(negedge clk);
    end
  endtask

  int total_len;

  initial begin
    total_len = cyc_of(TR_NS) + cyc_of(TC_NS) + cyc_of(TX_NS) + 4 + ZQ_CYC + 5;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    push(0,0,4'b0111,0,0,0,"R1");           // R1 reset state
    run_cycles(1);
    rst_n = 1'b1;
    push_sequence(total_len);               // R2 R3 R4 R5 R6 R7 R8
    run_cycles(total_len);

    rst_n = 1'b0;                           // restart for a second run
    @(negedge clk);
    rst_n = 1'b1;
    push_sequence(32);                      // stop inside the CKE-high wait
    run_cycles(32);
    rst_n = 1'b0;                           // R9 mid-sequence reset
    @(negedge clk);
    push(0,0,4'b0111,0,0,0,"R9");
    run_cycles(1);
    rst_n = 1'b1;
    push_sequence(total_len);               // R9 full replay
    run_cycles(total_len);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule